// File: doc/BRIEF.md
# Monochrome Raster Scanout with Cycle-Stealing Fetch

This block produces the timing for a 640x400, one-bit-per-pixel display running from a pixel clock. It also reads the frame buffer out of a memory that it shares with a processor. For every group of 8 pixels it reads one byte. The read happens in the last clock of the group that comes before the pixels it feeds, so each byte is in place on the first pixel of its group. The byte's bits then appear on the video output one per clock, most significant bit first.

Each read takes the memory bus for exactly one clock. In that clock the processor's ready and bus-enable lines are pulled low. The fetch address does not come from the beam position. It comes from a linear byte counter that is cleared during vertical blanking and advances by one after each read. The counter value is ORed onto an aligned frame-buffer base address.

Horizontal and vertical counts, blanking flags and sync pulses all come from parameters. The defaults give 800 clocks per line and 449 lines per frame.

Top module: `vga_scanout`

## Requirements
- R1: Each line lasts H_VIS+H_FP+H_SYNC+H_BP clocks (default 800). hsync_o is active low for the H_SYNC clocks that start at position H_VIS+H_FP (default positions 656..751), and is high at all other times.
- R2: Each frame lasts V_VIS+V_FP+V_SYNC+V_BP lines (default 449). vsync_o is active high during the V_SYNC lines that start at line V_VIS+V_FP (default lines 412..413), and is low at all other times.
- R3: video_o can be 1 only when the horizontal position is below H_VIS and the line is below V_VIS. In every other position it is 0.
- R4: Visible pixel x of line y shows bit 7-(x mod 8) of the frame-buffer byte with index y*(H_VIS/8)+x/8. Bit 7 is shown first.
- R5: mem_rd_o is high for one clock in the last clock of every 8-clock group that is followed by a visible group. This includes clock H_TOT-1 of the line before each visible line. That gives H_VIS/8 reads for each visible line and no other reads.
- R6: During a read, mem_addr_o equals FB_BASE OR the index of the byte being fetched (y*(H_VIS/8)+group). The first read of a frame uses FB_BASE itself, and each read is one above the previous read in the same frame.
- R7: cpu_rdy_o and cpu_be_o are both low in exactly the clocks where mem_rd_o is high, and are high at all other times.
- R8: While rst_ni is low, and at the first position after its release, the block is at horizontal position 0 of line V_VIS. In that state hsync_o=1, vsync_o=0, video_o=0, mem_rd_o=0, cpu_rdy_o=cpu_be_o=1 and mem_addr_o=FB_BASE.
- R9: mem_data_i is sampled at the clock edge that ends a read cycle. The memory must present the data combinationally within that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_data_i | input | 8 | Read data from video memory |
| mem_addr_o | output | ADDR_W | Fetch address |
| mem_rd_o | output | 1 | Read strobe, one clock per fetch |
| cpu_rdy_o | output | 1 | Processor ready, low while stealing |
| cpu_be_o | output | 1 | Processor bus enable, low while stealing |
| hsync_o | output | 1 | Horizontal sync, active low |
| vsync_o | output | 1 | Vertical sync, active high |
| video_o | output | 1 | Pixel output |

## Verification
The bench targets the read that crosses a line boundary, at the last clock of the previous line. A design that got this wrong would lose the first byte of every line or display it one group late. The bench also targets the read for line 0, which happens while vertical blanking is still set. A clear of the address counter that does not exclude this read would shift the whole frame by one byte. The bench checks that reads stop after the last visible group and on blank lines, because an extra read would both stall the processor and advance the address. Every pixel is compared bit by bit against the expected byte index, which catches a reversed bit order or a byte that is off by one. A reset in the middle of the visible area checks that the address counter and all flags return to their idle values.

// File: rtl/vga_pkg.sv
package vga_pkg;
  localparam int unsigned PIX_PER_BYTE = 8;
  localparam int unsigned GRP_W        = 3;
  typedef logic [7:0] pix_byte_t;
endpackage

// File: rtl/vga_timing.sv
module vga_timing #(
  parameter int unsigned H_VIS  = 640,
  parameter int unsigned H_FP   = 16,
  parameter int unsigned H_SYNC = 96,
  parameter int unsigned H_BP   = 48,
  parameter int unsigned V_VIS  = 400,
  parameter int unsigned V_FP   = 12,
  parameter int unsigned V_SYNC = 2,
  parameter int unsigned V_BP   = 35,
  localparam int unsigned H_TOT = H_VIS + H_FP + H_SYNC + H_BP,
  localparam int unsigned V_TOT = V_VIS + V_FP + V_SYNC + V_BP,
  localparam int unsigned HW    = $clog2(H_TOT),
  localparam int unsigned VW    = $clog2(V_TOT)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [HW-1:0] hcnt_o,
  output logic [VW-1:0] vcnt_o,
  output logic          hblank_o,
  output logic          vblank_o,
  output logic          hsync_o,
  output logic          vsync_o
);
  logic line_end;
  assign line_end = (hcnt_o == HW'(H_TOT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_o <= '0;
      vcnt_o <= VW'(V_VIS);
    end else begin
      hcnt_o <= line_end ? '0 : hcnt_o + 1'b1;
      if (line_end) vcnt_o <= (vcnt_o == VW'(V_TOT - 1)) ? '0 : vcnt_o + 1'b1;
    end
  end

  // flags toggle one clock ahead so they are registered at the boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hblank_o <= 1'b0;
      vblank_o <= 1'b1;
      hsync_o  <= 1'b1;
      vsync_o  <= 1'b0;
    end else begin
      if (hcnt_o == HW'(H_VIS - 1))                  hblank_o <= 1'b1;
      else if (line_end)                             hblank_o <= 1'b0;
      if (hcnt_o == HW'(H_VIS + H_FP - 1))           hsync_o  <= 1'b0;
      else if (hcnt_o == HW'(H_VIS + H_FP + H_SYNC - 1)) hsync_o <= 1'b1;
      if (line_end) begin
        if (vcnt_o == VW'(V_VIS - 1))                vblank_o <= 1'b1;
        else if (vcnt_o == VW'(V_TOT - 1))           vblank_o <= 1'b0;
        if (vcnt_o == VW'(V_VIS + V_FP - 1))         vsync_o  <= 1'b1;
        else if (vcnt_o == VW'(V_VIS + V_FP + V_SYNC - 1)) vsync_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vga_fetch.sv
module vga_fetch
  import vga_pkg::*;
#(
  parameter int unsigned H_VIS   = 640,
  parameter int unsigned H_TOT   = 800,
  parameter int unsigned V_VIS   = 400,
  parameter int unsigned V_TOT   = 449,
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned FB_BASE = 32'h8000,
  localparam int unsigned HW     = $clog2(H_TOT),
  localparam int unsigned VW     = $clog2(V_TOT),
  localparam int unsigned BYTES  = (H_VIS / PIX_PER_BYTE) * V_VIS,
  localparam int unsigned CW     = $clog2(BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HW-1:0]     hcnt_i,
  input  logic [VW-1:0]     vcnt_i,
  input  logic              vblank_i,
  output logic              rd_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic          fetch_en;
  logic          fetch_vis;
  logic          last_grp;
  logic [CW-1:0] cnt;

  // window opens one group before the display area, closes one group early
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                             fetch_en <= 1'b1;
    else if (hcnt_i == HW'(H_TOT - PIX_PER_BYTE - 1))        fetch_en <= 1'b1;
    else if (hcnt_i == HW'(H_VIS - PIX_PER_BYTE - 1))        fetch_en <= 1'b0;
  end

  // vertical qualifier refers to the line the fetched byte belongs to
  assign last_grp  = (hcnt_i >= HW'(H_TOT - PIX_PER_BYTE));
  assign fetch_vis = last_grp ? ((vcnt_i == VW'(V_TOT - 1)) || (vcnt_i < VW'(V_VIS - 1)))
                              : (vcnt_i < VW'(V_VIS));
  assign rd_o      = fetch_en && fetch_vis && (&hcnt_i[GRP_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt <= '0;
    else if (rd_o)     cnt <= cnt + 1'b1;
    else if (vblank_i) cnt <= '0;
  end

  assign addr_o = ADDR_W'(FB_BASE) | ADDR_W'(cnt);
endmodule

// File: rtl/vga_shift.sv
module vga_shift
  import vga_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  pix_byte_t        data_i,
  input  logic [GRP_W-1:0] sel_i,
  input  logic             blank_i,
  output logic             video_o
);
  pix_byte_t pix_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pix_q <= '0;
    else if (load_i) pix_q <= data_i;
  end

  // bit 7 first: index is the complement of the in-group position
  assign video_o = !blank_i && pix_q[~sel_i];
endmodule

// File: rtl/vga_scanout.sv
module vga_scanout
  import vga_pkg::*;
#(
  parameter int unsigned H_VIS   = 640,
  parameter int unsigned H_FP    = 16,
  parameter int unsigned H_SYNC  = 96,
  parameter int unsigned H_BP    = 48,
  parameter int unsigned V_VIS   = 400,
  parameter int unsigned V_FP    = 12,
  parameter int unsigned V_SYNC  = 2,
  parameter int unsigned V_BP    = 35,
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned FB_BASE = 32'h8000,
  localparam int unsigned H_TOT  = H_VIS + H_FP + H_SYNC + H_BP,
  localparam int unsigned V_TOT  = V_VIS + V_FP + V_SYNC + V_BP,
  localparam int unsigned HW     = $clog2(H_TOT),
  localparam int unsigned VW     = $clog2(V_TOT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        mem_data_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              cpu_rdy_o,
  output logic              cpu_be_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              video_o
);
  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic          hblank, vblank;

  vga_timing #(
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
  ) u_timing (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .hcnt_o(hcnt), .vcnt_o(vcnt),
    .hblank_o(hblank), .vblank_o(vblank),
    .hsync_o(hsync_o), .vsync_o(vsync_o)
  );

  vga_fetch #(
    .H_VIS(H_VIS), .H_TOT(H_TOT), .V_VIS(V_VIS), .V_TOT(V_TOT),
    .ADDR_W(ADDR_W), .FB_BASE(FB_BASE)
  ) u_fetch (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .hcnt_i(hcnt), .vcnt_i(vcnt), .vblank_i(vblank),
    .rd_o(mem_rd_o), .addr_o(mem_addr_o)
  );

  vga_shift u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .load_i(mem_rd_o), .data_i(mem_data_i),
    .sel_i(hcnt[GRP_W-1:0]), .blank_i(hblank || vblank),
    .video_o(video_o)
  );

  // bus is stolen for exactly the read clock
  assign cpu_rdy_o = !mem_rd_o;
  assign cpu_be_o  = !mem_rd_o;
endmodule

// File: rtl/vga_scanout_chk.sv
module vga_scanout_chk #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned FB_BASE = 32'h8000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_rd_o,
  input logic              cpu_rdy_o,
  input logic              cpu_be_o,
  input logic              hsync_o,
  input logic              vsync_o,
  input logic              video_o
);
  logic              have_prev;
  logic [ADDR_W-1:0] last_addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_prev <= 1'b0;
      last_addr <= '0;
    end else if (mem_rd_o) begin
      have_prev <= 1'b1;
      last_addr <= mem_addr_o;
    end else if (vsync_o) begin
      have_prev <= 1'b0;
    end
  end

  a_r7_stall_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> (!cpu_rdy_o && !cpu_be_o));
  a_r7_free_otherwise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_rd_o |-> (cpu_rdy_o && cpu_be_o));
  a_r5_single_cycle_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> !mem_rd_o);
  a_r3_dark_in_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    video_o |-> (hsync_o && !vsync_o));
  a_r6_first_at_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o && !have_prev) |-> (mem_addr_o == ADDR_W'(FB_BASE)));
  a_r6_linear_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o && have_prev) |-> (mem_addr_o == last_addr + 1'b1));
  a_r5_no_read_in_vsync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vsync_o |-> !mem_rd_o);
endmodule

bind vga_scanout vga_scanout_chk #(.ADDR_W(ADDR_W), .FB_BASE(FB_BASE)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o),
  .cpu_rdy_o(cpu_rdy_o), .cpu_be_o(cpu_be_o), .hsync_o(hsync_o),
  .vsync_o(vsync_o), .video_o(video_o)
);

// File: tb/vga_scanout_tb.sv
module vga_scanout_tb_top;
  localparam int CLK_P  = 10;
  localparam int HV = 64, HFP = 8, HS = 16, HBP = 8;
  localparam int VV = 6,  VFP = 2, VS = 2,  VBP = 2;
  localparam int HT = HV + HFP + HS + HBP;
  localparam int VT = VV + VFP + VS + VBP;
  localparam int BPL = HV / 8;
  localparam int AW = 16;
  localparam logic [AW-1:0] BASE = 16'h8000;
  localparam int NPAT = 5;
  // {constant-fill mode, seed}
  localparam logic [8:0] PATS [NPAT] = '{9'h100, 9'h1FF, 9'h05A, 9'h1A5, 9'h033};

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] mem_data;
  logic [AW-1:0] mem_addr;
  logic mem_rd, cpu_rdy, cpu_be, hsync, vsync, video;
  int checks = 0, errors = 0;
  int bx, by;
  logic chk_on = 1'b0;
  logic [8:0] pat = 9'h05A;
  int rd_count;

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [7:0] pat_byte(logic [8:0] p, int idx);
    if (p[8]) return p[7:0];
    return 8'((idx * 29 + 7) ^ int'(p[7:0]));
  endfunction

  assign mem_data = pat_byte(pat, int'(mem_addr & 16'h7FFF));

  vga_scanout #(
    .H_VIS(HV), .H_FP(HFP), .H_SYNC(HS), .H_BP(HBP),
    .V_VIS(VV), .V_FP(VFP), .V_SYNC(VS), .V_BP(VBP),
    .ADDR_W(AW), .FB_BASE(32'h8000)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mem_data_i(mem_data),
    .mem_addr_o(mem_addr), .mem_rd_o(mem_rd), .cpu_rdy_o(cpu_rdy),
    .cpu_be_o(cpu_be), .hsync_o(hsync), .vsync_o(vsync), .video_o(video)
  );

  // bench beam position, derived from the requirements
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin bx <= 0; by <= VV; end
    else if (bx == HT - 1) begin bx <= 0; by <= (by == VT - 1) ? 0 : by + 1; end
    else bx <= bx + 1;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at x=%0d y=%0d: actual %h expected %h", req, bx, by, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on && rst_n) begin
      int sl, sg, sidx;
      logic exp_rd, exp_vid;
      if (bx == HT - 1) begin sl = (by == VT - 1) ? 0 : by + 1; sg = 0; end
      else begin sl = by; sg = bx / 8 + 1; end
      sidx   = sl * BPL + sg;
      exp_rd = (bx % 8 == 7) && (sl < VV) && (sg < BPL);
      exp_vid = (bx < HV && by < VV) ? pat_byte(pat, by * BPL + bx / 8)[7 - bx % 8] : 1'b0;
      check("R1 hsync", 32'(hsync), 32'(!(bx >= HV + HFP && bx < HV + HFP + HS)));
      check("R2 vsync", 32'(vsync), 32'(by >= VV + VFP && by < VV + VFP + VS));
      check("R3/R4/R9 video", 32'(video), 32'(exp_vid));
      check("R5 read strobe", 32'(mem_rd), 32'(exp_rd));
      check("R7 rdy", 32'(cpu_rdy), 32'(!exp_rd));
      check("R7 be", 32'(cpu_be), 32'(!exp_rd));
      if (exp_rd) check("R6 address", 32'(mem_addr), 32'(BASE | 16'(sidx)));
      if (mem_rd) rd_count++;
    end
  end

  task automatic wait_pos(int x, int y);
    @(negedge clk);
    while (!(bx == x && by == y)) @(negedge clk);
  endtask

  task automatic check_reset_state();
    check("R8 hsync", 32'(hsync), 32'd1);
    check("R8 vsync", 32'(vsync), 32'd0);
    check("R8 video", 32'(video), 32'd0);
    check("R8 rd", 32'(mem_rd), 32'd0);
    check("R8 rdy/be", {30'd0, cpu_rdy, cpu_be}, 32'd3);
    check("R8 addr", 32'(mem_addr), 32'(BASE));
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;
    chk_on = 1'b1;
    // walk the pattern table, one full frame each
    for (int i = 0; i < NPAT; i++) begin
      wait_pos(0, VV);
      pat = PATS[i];
      rd_count = 0;
      wait_pos(HT - 1, VT - 1);
      wait_pos(0, VV);
      // R5: exactly one read per visible group per frame (counter spans frame)
      check("R5 reads per frame", 32'(rd_count), 32'(VV * BPL));
    end
    // directed: reset in the middle of the visible area
    wait_pos(20, 2);
    rst_n = 1'b0;
    #1;
    check_reset_state();
    repeat (2) @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;
    pat = 9'h0C3;
    wait_pos(HT - 1, VT - 1);
    check("R6 line-0 read at base", 32'(mem_addr), 32'(BASE));
    check("R5 line-0 read before frame", 32'(mem_rd), 32'd1);
    wait_pos(0, VV);
    chk_on = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule